// File: doc/BRIEF.md
# BCD Real-Time Clock Core

This core keeps calendar time as packed BCD bytes: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. A one-cycle pulse on `sec_tick`, produced elsewhere by a prescaler, asks for the next second. The core first raises an update-in-progress flag for a fixed number of clock cycles. When that window closes, it advances the time by one second, carrying through the calendar.

Software reaches the core through a small register file of 8-bit registers. It holds the time, three alarm bytes placed between the time bytes, and four control/status registers. To read the time consistently, software waits for the update flag to read 0 and then reads the time bytes. To load a new time, software sets the freeze bit, writes the time bytes, and clears the freeze bit again. Each second step sets an update flag in the status register. The step also sets an alarm flag when the new hours, minutes and seconds equal the alarm bytes. Reading the status register clears both flags.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read: seconds, minutes and hours 0x00; day of week 0x01; day of month 0x01; month 0x01; year 0x00; all three alarm bytes 0x00; control A 0x26; control B 0x02; status 0x00; control D 0x80.
- R2: Register indices are fixed. Seconds 0x0, seconds alarm 0x1, minutes 0x2, minutes alarm 0x3, hours 0x4, hours alarm 0x5, day of week 0x6, day of month 0x7, month 0x8, year 0x9, control A 0xA, control B 0xB, status 0xC, control D 0xD. Indices 0xE and 0xF read 0x00. The alarm bytes can be written at any time and read back in full.
- R3: A tick while the freeze bit is 0 makes bit 7 of control A read 1 for exactly UIP_CYCLES cycles. The time advances one second at the clock edge that clears that bit. A tick that arrives while the window is open is ignored.
- R4: The freeze bit is bit 7 of control B. While it is 1, ticks do not advance the time, bit 7 of control A reads 0, and writes to the time bytes take effect. While it is 0, writes to the time bytes are ignored.
- R5: A written time byte keeps only its valid low bits, and the upper bits read 0. Seconds and minutes keep 7 bits, hours and day of month 6, month 5, day of week 3, and year all 8.
- R6: Seconds and minutes roll from 59 to 00, and hours from 23 to 00. Each rollover carries into the next field.
- R7: Day of week advances on each day rollover, from 1 (Sunday) up to 7 (Saturday), and then back to 1.
- R8: Day of month rolls to 01 after the last day of the month. Months 04, 06, 09 and 11 end at 30, month 02 ends at 29 when the year is a multiple of 4 and at 28 otherwise, and all other months end at 31. Month rolls from 12 to 01 and carries into the year, and the year rolls from 99 to 00.
- R9: Each second step sets bit 4 of the status register. The step also sets bit 5 when the new seconds, minutes and hours equal the three alarm bytes.
- R10: A read of the status register returns the flags and clears them at that edge. A flag-setting event in the same cycle wins over the clear. Writes to the status register have no effect.
- R11: Control D always reads 0x80 and ignores writes. Bit 7 of control A is read-only, and bits 6:0 of control A (including time-base bit 5 and the rate nibble) are plain storage. All 8 bits of control B are storage, including 24-hour bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse requesting the next second |
| bus_addr | input | 4 | Register index for a read or a write |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; needed only for clear-on-read side effects |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |

## Verification
A corrupted carry chain (a wrong month length, a missed leap year, a day of week reaching 0 or 8) shows up in the time bytes right after the step that closes the update window. That is UIP_CYCLES cycles after the tick, so the bench loads a time just before each boundary and reads it back one window later. A fault in the update sequencer shows on control A bit 7 in the cycle right after the tick, either as a window of the wrong length or as one that stays open while frozen. Flag faults show on the very next status read, because the clear happens at that same edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;

  localparam int unsigned SEC_W = 7;
  localparam int unsigned MIN_W = 7;
  localparam int unsigned HR_W  = 6;
  localparam int unsigned DOW_W = 3;
  localparam int unsigned DOM_W = 6;
  localparam int unsigned MON_W = 5;
  localparam int unsigned YR_W  = 8;

  localparam logic [ADDR_W-1:0] IDX_SEC    = 4'h0;
  localparam logic [ADDR_W-1:0] IDX_SEC_AL = 4'h1;
  localparam logic [ADDR_W-1:0] IDX_MIN    = 4'h2;
  localparam logic [ADDR_W-1:0] IDX_MIN_AL = 4'h3;
  localparam logic [ADDR_W-1:0] IDX_HR     = 4'h4;
  localparam logic [ADDR_W-1:0] IDX_HR_AL  = 4'h5;
  localparam logic [ADDR_W-1:0] IDX_DOW    = 4'h6;
  localparam logic [ADDR_W-1:0] IDX_DOM    = 4'h7;
  localparam logic [ADDR_W-1:0] IDX_MON    = 4'h8;
  localparam logic [ADDR_W-1:0] IDX_YR     = 4'h9;
  localparam logic [ADDR_W-1:0] IDX_CTL_A  = 4'hA;
  localparam logic [ADDR_W-1:0] IDX_CTL_B  = 4'hB;
  localparam logic [ADDR_W-1:0] IDX_STAT   = 4'hC;
  localparam logic [ADDR_W-1:0] IDX_CTL_D  = 4'hD;

  localparam logic [6:0]        CTL_A_RST  = 7'h26;
  localparam logic [DATA_W-1:0] CTL_B_RST  = 8'h02;
  localparam logic [DATA_W-1:0] CTL_D_VAL  = 8'h80;

  localparam int unsigned FREEZE_BIT = 7;
  localparam int unsigned UF_BIT     = 4;
  localparam int unsigned AF_BIT     = 5;

  typedef struct packed {
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mon;
    logic [DOM_W-1:0] dom;
    logic [DOW_W-1:0] dow;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } rtc_time_t;

  typedef struct packed {
    logic [7:0] val;
    logic       carry;
  } bcd_roll_t;

  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] yr_bcd);
    logic [6:0] b;
    b = bcd_to_bin(yr_bcd);
    return (b[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon_bcd,
                                                input logic [7:0] yr_bcd);
    case (mon_bcd)
      8'h02:                     return leap_year(yr_bcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

  function automatic bcd_roll_t bcd_roll(input logic [7:0] v,
                                         input logic [7:0] last,
                                         input logic [7:0] first);
    bcd_roll_t r;
    if (v >= last) begin
      r.val   = first;
      r.carry = 1'b1;
    end else begin
      r.val   = bcd_inc8(v);
      r.carry = 1'b0;
    end
    return r;
  endfunction

  function automatic logic is_time_idx(input logic [ADDR_W-1:0] a);
    return (a == IDX_SEC) || (a == IDX_MIN) || (a == IDX_HR) ||
           (a == IDX_DOW) || (a == IDX_DOM) || (a == IDX_MON) || (a == IDX_YR);
  endfunction

endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int unsigned UIP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic freeze,
  output logic uip,
  output logic step
);
  localparam int unsigned CNT_W = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(UIP_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (freeze) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (tick) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end
  end

  assign uip  = busy_q && !freeze;
  assign step = busy_q && (cnt_q == '0) && !freeze;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              freeze,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output rtc_time_t         time_q,
  output logic [DATA_W-1:0] al_sec_q,
  output logic [DATA_W-1:0] al_min_q,
  output logic [DATA_W-1:0] al_hr_q,
  output logic              alarm_hit,
  output logic              day_carry
);
  rtc_time_t nxt;
  bcd_roll_t r_sec, r_min, r_hr, r_dom, r_mon, r_yr;
  logic      sec_c, min_c, mon_c;

  always_comb begin
    r_sec = bcd_roll({1'b0, time_q.sec}, 8'h59, 8'h00);
    r_min = bcd_roll({1'b0, time_q.min}, 8'h59, 8'h00);
    r_hr  = bcd_roll({2'b0, time_q.hr},  8'h23, 8'h00);
    r_dom = bcd_roll({2'b0, time_q.dom},
                     month_last_day({3'b0, time_q.mon}, time_q.yr), 8'h01);
    r_mon = bcd_roll({3'b0, time_q.mon}, 8'h12, 8'h01);
    r_yr  = bcd_roll(time_q.yr, 8'h99, 8'h00);

    sec_c     = r_sec.carry;
    min_c     = sec_c && r_min.carry;
    day_carry = min_c && r_hr.carry;
    mon_c     = day_carry && r_dom.carry;

    nxt     = time_q;
    nxt.sec = r_sec.val[SEC_W-1:0];
    if (sec_c) nxt.min = r_min.val[MIN_W-1:0];
    if (min_c) nxt.hr  = r_hr.val[HR_W-1:0];
    if (day_carry) begin
      nxt.dom = r_dom.val[DOM_W-1:0];
      nxt.dow = (time_q.dow >= 3'd7 || time_q.dow == 3'd0) ? 3'd1
                                                           : time_q.dow + 3'd1;
    end
    if (mon_c) nxt.mon = r_mon.val[MON_W-1:0];
    if (mon_c && r_mon.carry) nxt.yr = r_yr.val;
  end

  assign alarm_hit = step &&
                     ({1'b0, nxt.sec} == al_sec_q) &&
                     ({1'b0, nxt.min} == al_min_q) &&
                     ({2'b0, nxt.hr}  == al_hr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q.sec <= '0;
      time_q.min <= '0;
      time_q.hr  <= '0;
      time_q.dow <= 3'd1;
      time_q.dom <= 6'h01;
      time_q.mon <= 5'h01;
      time_q.yr  <= '0;
    end else if (step) begin
      time_q <= nxt;
    end else if (wr_en && freeze) begin
      case (wr_idx)
        IDX_SEC: time_q.sec <= wr_data[SEC_W-1:0];
        IDX_MIN: time_q.min <= wr_data[MIN_W-1:0];
        IDX_HR:  time_q.hr  <= wr_data[HR_W-1:0];
        IDX_DOW: time_q.dow <= wr_data[DOW_W-1:0];
        IDX_DOM: time_q.dom <= wr_data[DOM_W-1:0];
        IDX_MON: time_q.mon <= wr_data[MON_W-1:0];
        IDX_YR:  time_q.yr  <= wr_data[YR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_sec_q <= '0;
      al_min_q <= '0;
      al_hr_q  <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_SEC_AL: al_sec_q <= wr_data;
        IDX_MIN_AL: al_min_q <= wr_data;
        IDX_HR_AL:  al_hr_q  <= wr_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  input  logic              alarm_hit,
  output logic [6:0]        ctl_a_q,
  output logic [DATA_W-1:0] ctl_b_q,
  output logic [DATA_W-1:0] flags_q,
  output logic              freeze
);
  logic af_q, uf_q;
  logic stat_read;

  assign stat_read = rd_en && (idx == IDX_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a_q <= CTL_A_RST;
      ctl_b_q <= CTL_B_RST;
    end else if (wr_en) begin
      if (idx == IDX_CTL_A) ctl_a_q <= wr_data[6:0];
      if (idx == IDX_CTL_B) ctl_b_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      af_q <= 1'b0;
      uf_q <= 1'b0;
    end else begin
      af_q <= (af_q && !stat_read) || alarm_hit;
      uf_q <= (uf_q && !stat_read) || step;
    end
  end

  always_comb begin
    flags_q         = '0;
    flags_q[AF_BIT] = af_q;
    flags_q[UF_BIT] = uf_q;
  end

  assign freeze = ctl_b_q[FREEZE_BIT];

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned UIP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              upd_uip;
  logic              upd_step;
  logic              freeze;
  logic              alarm_hit;
  logic              day_carry;
  rtc_time_t         time_q;
  logic [DATA_W-1:0] al_sec_q, al_min_q, al_hr_q;
  logic [6:0]        ctl_a_q;
  logic [DATA_W-1:0] ctl_b_q;
  logic [DATA_W-1:0] flags_q;

  rtc_update_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sec_tick),
    .freeze (freeze),
    .uip    (upd_uip),
    .step   (upd_step)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (upd_step),
    .freeze    (freeze),
    .wr_en     (bus_wr),
    .wr_idx    (bus_addr),
    .wr_data   (bus_wdata),
    .time_q    (time_q),
    .al_sec_q  (al_sec_q),
    .al_min_q  (al_min_q),
    .al_hr_q   (al_hr_q),
    .alarm_hit (alarm_hit),
    .day_carry (day_carry)
  );

  rtc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .rd_en     (bus_rd),
    .idx       (bus_addr),
    .wr_data   (bus_wdata),
    .step      (upd_step),
    .alarm_hit (alarm_hit),
    .ctl_a_q   (ctl_a_q),
    .ctl_b_q   (ctl_b_q),
    .flags_q   (flags_q),
    .freeze    (freeze)
  );

  always_comb begin
    case (bus_addr)
      IDX_SEC:    bus_rdata = {1'b0, time_q.sec};
      IDX_SEC_AL: bus_rdata = al_sec_q;
      IDX_MIN:    bus_rdata = {1'b0, time_q.min};
      IDX_MIN_AL: bus_rdata = al_min_q;
      IDX_HR:     bus_rdata = {2'b0, time_q.hr};
      IDX_HR_AL:  bus_rdata = al_hr_q;
      IDX_DOW:    bus_rdata = {5'b0, time_q.dow};
      IDX_DOM:    bus_rdata = {2'b0, time_q.dom};
      IDX_MON:    bus_rdata = {3'b0, time_q.mon};
      IDX_YR:     bus_rdata = time_q.yr;
      IDX_CTL_A:  bus_rdata = {upd_uip, ctl_a_q};
      IDX_CTL_B:  bus_rdata = ctl_b_q;
      IDX_STAT:   bus_rdata = flags_q;
      IDX_CTL_D:  bus_rdata = CTL_D_VAL;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sec_tick,
  input logic              upd_uip,
  input logic              upd_step,
  input logic              freeze,
  input rtc_time_t         time_q,
  input logic [DATA_W-1:0] flags_q
);
  logic time_wr;
  assign time_wr = bus_wr && is_time_idx(bus_addr);

  // R3 and R4: the time changes only by a step or an allowed write
  assert_time_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_step && !time_wr) |=> $stable(time_q));

  // R3: a step closes a window that was already open
  assert_step_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_step |-> $past(upd_uip));

  // R3: a window opens only after a tick
  assert_window_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_uip) |-> $past(sec_tick));

  // R4: frozen clock never steps
  assert_frozen_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !upd_step && !upd_uip);

  // R6: seconds wrap
  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_step && time_q.sec == 7'h59) |=> time_q.sec == 7'h00);

  // R9: every step raises the update flag
  assert_uf_after_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_step |=> flags_q[UF_BIT]);

  // R10: a status read with no event clears all flags
  assert_stat_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == IDX_STAT && !upd_step) |=> flags_q == '0);

  // R11: control D is constant
  assert_ctl_d_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == IDX_CTL_D) |-> bus_rdata == CTL_D_VAL);

endmodule

bind bcd_rtc_core rtc_core_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .sec_tick  (sec_tick),
  .upd_uip   (upd_uip),
  .upd_step  (upd_step),
  .freeze    (freeze),
  .time_q    (time_q),
  .flags_q   (flags_q)
);

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int UIP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  bcd_rtc_core #(.UIP_CYCLES(UIP)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse_tick();
    sec_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic next_sec();
    pulse_tick();
    repeat (UIP + 2) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] yr, mon, dom, dow, hr, mi, se);
    wr(4'hB, 8'h82);
    wr(4'h9, yr); wr(4'h8, mon); wr(4'h7, dom); wr(4'h6, dow);
    wr(4'h4, hr); wr(4'h2, mi); wr(4'h0, se);
    wr(4'hB, 8'h02);
  endtask

  task automatic test_reset();
    rd_chk("R1 sec", 4'h0, 8'h00);  rd_chk("R1 min", 4'h2, 8'h00);
    rd_chk("R1 hr", 4'h4, 8'h00);   rd_chk("R1 dow", 4'h6, 8'h01);
    rd_chk("R1 dom", 4'h7, 8'h01);  rd_chk("R1 mon", 4'h8, 8'h01);
    rd_chk("R1 yr", 4'h9, 8'h00);   rd_chk("R1 al", 4'h1, 8'h00);
    rd_chk("R1 al", 4'h3, 8'h00);   rd_chk("R1 al", 4'h5, 8'h00);
    rd_chk("R1 ctlA", 4'hA, 8'h26); rd_chk("R1 ctlB", 4'hB, 8'h02);
    rd_chk("R1 stat", 4'hC, 8'h00); rd_chk("R1 ctlD", 4'hD, 8'h80);
  endtask

  task automatic test_map();
    wr(4'h1, 8'hA1); wr(4'h3, 8'hB3); wr(4'h5, 8'hC5);
    rd_chk("R2 sec alarm", 4'h1, 8'hA1);
    rd_chk("R2 min alarm", 4'h3, 8'hB3);
    rd_chk("R2 hr alarm", 4'h5, 8'hC5);
    rd_chk("R2 idx E", 4'hE, 8'h00);
    rd_chk("R2 idx F", 4'hF, 8'h00);
    rd_chk("R2 sec unaffected", 4'h0, 8'h00);
    wr(4'hA, 8'hFF); rd_chk("R11 ctlA bit7 ro", 4'hA, 8'h7F);
    wr(4'hA, 8'h26); rd_chk("R11 ctlA store", 4'hA, 8'h26);
    wr(4'hB, 8'h06); rd_chk("R11 ctlB store", 4'hB, 8'h06);
    wr(4'hB, 8'h02);
    wr(4'hD, 8'h00); rd_chk("R11 ctlD fixed", 4'hD, 8'h80);
    wr(4'h1, 8'h00); wr(4'h3, 8'h00); wr(4'h5, 8'h00);
  endtask

  task automatic test_uip();
    pulse_tick();
    for (int i = 0; i < UIP; i++) rd_chk("R3 uip high", 4'hA, 8'hA6);
    rd_chk("R3 uip low", 4'hA, 8'h26);
    rd_chk("R3 sec advanced", 4'h0, 8'h01);
    pulse_tick();
    pulse_tick();
    repeat (UIP + 4) @(negedge clk);
    rd_chk("R3 extra tick ignored", 4'h0, 8'h02);
  endtask

  task automatic test_freeze();
    wr(4'h0, 8'h45);
    rd_chk("R4 write ignored running", 4'h0, 8'h02);
    wr(4'hB, 8'h82);
    pulse_tick();
    rd_chk("R4 no uip frozen", 4'hA, 8'h26);
    repeat (UIP + 2) @(negedge clk);
    rd_chk("R4 no advance frozen", 4'h0, 8'h02);
    wr(4'h0, 8'h45);
    rd_chk("R4 write frozen", 4'h0, 8'h45);
    wr(4'hB, 8'h02);
    next_sec();
    rd_chk("R4 resume", 4'h0, 8'h46);
  endtask

  task automatic test_masks();
    wr(4'hB, 8'h82);
    wr(4'h0, 8'hFF); rd_chk("R5 sec mask", 4'h0, 8'h7F);
    wr(4'h2, 8'hFF); rd_chk("R5 min mask", 4'h2, 8'h7F);
    wr(4'h4, 8'hFF); rd_chk("R5 hr mask", 4'h4, 8'h3F);
    wr(4'h7, 8'hFF); rd_chk("R5 dom mask", 4'h7, 8'h3F);
    wr(4'h8, 8'hFF); rd_chk("R5 mon mask", 4'h8, 8'h1F);
    wr(4'h6, 8'hFF); rd_chk("R5 dow mask", 4'h6, 8'h07);
    wr(4'h9, 8'hFF); rd_chk("R5 yr full", 4'h9, 8'hFF);
    wr(4'hB, 8'h02);
  endtask

  task automatic test_carry();
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    next_sec();
    rd_chk("R6 sec wrap", 4'h0, 8'h00);
    rd_chk("R6 min wrap", 4'h2, 8'h00);
    rd_chk("R6 hr wrap", 4'h4, 8'h00);
    rd_chk("R7 dow 7 to 1", 4'h6, 8'h01);
    rd_chk("R8 dom wrap", 4'h7, 8'h01);
    rd_chk("R8 mon 12 to 01", 4'h8, 8'h01);
    rd_chk("R8 yr 99 to 00", 4'h9, 8'h00);
    set_time(8'h25, 8'h06, 8'h10, 8'h03, 8'h10, 8'h09, 8'h59);
    next_sec();
    rd_chk("R6 bcd min digit", 4'h2, 8'h10);
    rd_chk("R6 hr kept", 4'h4, 8'h10);
    rd_chk("R7 dow kept", 4'h6, 8'h03);
    set_time(8'h25, 8'h06, 8'h10, 8'h03, 8'h09, 8'h59, 8'h59);
    next_sec();
    rd_chk("R6 hr bcd digit", 4'h4, 8'h10);
    set_time(8'h25, 8'h06, 8'h10, 8'h03, 8'h23, 8'h59, 8'h59);
    next_sec();
    rd_chk("R7 dow step", 4'h6, 8'h04);
  endtask

  task automatic month_case(input string req, input logic [7:0] yr, mon, dom,
                            input logic [7:0] exp_mon, exp_dom);
    set_time(yr, mon, dom, 8'h01, 8'h23, 8'h59, 8'h59);
    next_sec();
    rd_chk(req, 4'h7, exp_dom);
    rd_chk(req, 4'h8, exp_mon);
  endtask

  task automatic test_months();
    month_case("R8 leap feb 28", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    month_case("R8 leap feb 29", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    month_case("R8 plain feb 28", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    month_case("R8 apr 30", 8'h25, 8'h04, 8'h30, 8'h05, 8'h01);
    month_case("R8 nov 30", 8'h25, 8'h11, 8'h30, 8'h12, 8'h01);
    month_case("R8 jan 31", 8'h25, 8'h01, 8'h31, 8'h02, 8'h01);
    month_case("R8 may 30", 8'h25, 8'h05, 8'h30, 8'h05, 8'h31);
    month_case("R8 year 00 leap", 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
  endtask

  task automatic test_alarm();
    logic [7:0] d;
    rd(4'hC, d);
    rd_chk("R10 cleared", 4'hC, 8'h00);
    wr(4'h1, 8'h05); wr(4'h3, 8'h30); wr(4'h5, 8'h12);
    set_time(8'h25, 8'h03, 8'h03, 8'h02, 8'h12, 8'h30, 8'h04);
    next_sec();
    rd_chk("R9 alarm and update", 4'hC, 8'h30);
    rd_chk("R10 read clears", 4'hC, 8'h00);
    next_sec();
    rd_chk("R9 update only", 4'hC, 8'h10);
    wr(4'hC, 8'hFF);
    rd_chk("R10 write ignored", 4'hC, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_map();
    test_uip();
    test_freeze();
    test_masks();
    test_carry();
    test_months();
    test_alarm();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule